// File: doc/BRIEF.md
# SMBus Register Slave with Strapped Address

This block is the serial-bus slave front end of a small management device. A fast system clock oversamples the bus clock and data lines. The block finds START and STOP conditions and shifts in the 7-bit target address and the direction bit. When the address is its own, it answers with an acknowledge.

In a write transfer, the first byte after the address loads a register pointer. Each byte after that lands in a small internal register file at the pointer, and the pointer moves on by one. In a read transfer, the block shifts out the register at the pointer, MSB first, and moves the pointer on after each byte. It keeps sending bytes for as long as the master acknowledges them.

The upper five address bits are fixed. The two lower bits come from a three-level strap pin. The board presents that pin as two digital sense lines, one read with a weak pull-down and one with a weak pull-up. The block decodes the strap once after reset and holds the result until the next reset. The data line is open-drain: `sda_pull_o` high means the block pulls SDA low.

Top module: `smb_strap_slave`

## Requirements
- R1: The slave address is binary 01011 followed by A1 and A0. A1:A0 are decoded from the sense pair (pull-down sense, pull-up sense) as follows: (0,0) grounded gives 00, (1,1) tied high gives 01, and (0,1) floating gives 10. The inconsistent pair (1,0) is also treated as floating and gives 10.
- R2: The strap is decoded in the first clock after reset is released. Later changes on the sense inputs leave the address unchanged until the next reset.
- R3: A falling SDA while SCL is high is a START. It restarts address reception from any state, even in the middle of a byte. A rising SDA while SCL is high is a STOP. A STOP releases SDA and returns the block to idle.
- R4: After a START, eight bits are taken MSB first: the seven address bits, then the direction bit (0 write, 1 read). On a match, SDA is pulled low for the ninth clock pulse. On a mismatch, no acknowledge is given, and the following bytes are neither acknowledged nor stored until the next START.
- R5: In a write transfer, the first byte after the address is acknowledged and loads the 8-bit register pointer.
- R6: Each later write byte is acknowledged, stored at the pointer, and followed by a pointer increment.
- R7: In a read transfer, the byte at the pointer is sent MSB first and the pointer increments. A master acknowledge (SDA low on the ninth pulse) makes the block send the next register. A read with no preceding command continues from the current pointer.
- R8: A master not-acknowledge ends a read. SDA then stays released, even under further clock pulses, until the next START.
- R9: The block changes its SDA drive only while SCL is low. The drive is steady while SCL is high.
- R10: The pointer is 8 bits wide and wraps from 255 to 0. A register is selected by the pointer modulo the register count (8 by default), so pointer 9 reaches register 1.
- R11: After reset, all registers read as zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_sense_lo_i | input | 1 | Strap pin sensed with a weak pull-down |
| strap_sense_hi_i | input | 1 | Strap pin sensed with a weak pull-up |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The address logic is tried with each of the four sense-pin pairs across separate resets. A strap change after reset is also applied. Together these separate a live decode from a latched one, and a correct decode table from a swapped one. Write bursts with several data bytes, with pointers at 9 and at 255, show whether the pointer increments and wraps. Reads that follow a command, reads that continue without one, and reads ended by a not-acknowledge then show the transmit path. A foreign address, a START cut into the middle of a byte, and free-running clock pulses after a not-acknowledge test that the block stays off the bus when it should.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [4:0] ADDR_PREFIX = 5'b01011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } smb_phase_e;

  // sense_lo: pin read with pull-down, sense_hi: pin read with pull-up
  function automatic logic [1:0] strap_decode(input logic sense_lo, input logic sense_hi);
    case ({sense_lo, sense_hi})
      2'b00:   return 2'b00;  // grounded
      2'b11:   return 2'b01;  // tied high
      default: return 2'b10;  // floating (or inconsistent)
    endcase
  endfunction

  function automatic logic [6:0] make_addr(input logic [1:0] low_bits);
    return {ADDR_PREFIX, low_bits};
  endfunction

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return p + 8'd1;
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_high,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign scl_high  = scl_s;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_strap.sv
module smb_strap
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sense_lo,
  input  logic       sense_hi,
  output logic [6:0] own_addr,
  output logic       strap_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr   <= make_addr(2'b10);
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      own_addr   <= make_addr(strap_decode(sense_lo, sense_hi));
      strap_done <= 1'b1;
    end
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [NREGS*DW-1:0] flat;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= '0;
      else if (wr_en && wr_idx == IW'(g))    q <= wr_data;
    end
    assign flat[g*DW +: DW] = q;
  end

  assign rd_data = flat[int'(rd_idx)*DW +: DW];
endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
  import smb_pkg::*;
#(
  parameter int NREGS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_sense_lo_i,
  input  logic strap_sense_hi_i,
  output logic sda_pull_o
);
  localparam int IW = $clog2(NREGS);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, scl_high, bus_start, bus_stop;
  logic [6:0] own_addr;
  logic strap_done;

  smb_state_e state;
  smb_phase_e phase;
  logic [2:0] bit_cnt;
  logic [7:0] sh;
  logic [7:0] tx;
  logic [7:0] ptr;
  logic       got8;
  logic       rw;
  logic       mack;
  logic       oe;

  logic       wr_en;
  logic [7:0] rd_data;
  logic       addr_hit;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );
  smb_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  smb_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_high(scl_high),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smb_strap u_strap (
    .clk(clk), .rst_n(rst_n),
    .sense_lo(strap_sense_lo_i), .sense_hi(strap_sense_hi_i),
    .own_addr(own_addr), .strap_done(strap_done)
  );

  assign addr_hit = (sh[7:1] == own_addr);
  assign wr_en    = (state == ST_RX) && scl_fall && got8 && (phase == PH_DATA);

  smb_regfile #(.NREGS(NREGS), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(ptr[IW-1:0]), .wr_data(sh),
    .rd_idx(ptr[IW-1:0]), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      got8    <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b1;
      oe      <= 1'b0;
    end else if (bus_start) begin
      state   <= ST_RX;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      got8    <= 1'b0;
      oe      <= 1'b0;
    end else if (bus_stop) begin
      state   <= ST_IDLE;
      got8    <= 1'b0;
      oe      <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (addr_hit) begin
                  rw    <= sh[0];
                  oe    <= 1'b1;
                  state <= ST_ACK;
                  phase <= sh[0] ? PH_DATA : PH_CMD;
                end else begin
                  state <= ST_IDLE;
                end
              end
              PH_CMD: begin
                ptr   <= sh;
                oe    <= 1'b1;
                state <= ST_ACK;
                phase <= PH_DATA;
              end
              default: begin
                ptr   <= ptr_next(ptr);
                oe    <= 1'b1;
                state <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx    <= rd_data;
              ptr   <= ptr_next(ptr);
              oe    <= ~rd_data[7];
              state <= ST_TX;
            end else begin
              oe    <= 1'b0;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              oe      <= 1'b0;
              state   <= ST_TXACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx      <= {tx[6:0], 1'b0};
              oe      <= ~tx[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack <= sda_s;
          end else if (scl_fall) begin
            if (!mack) begin
              tx    <= rd_data;
              ptr   <= ptr_next(ptr);
              oe    <= ~rd_data[7];
              state <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = oe;

endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk
  import smb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_high,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       sda_pull_o,
  input logic [6:0] own_addr,
  input logic       strap_done,
  input logic       wr_en,
  input logic [7:0] ptr,
  input smb_state_e state
);

  a_r9_drive_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_high && !bus_start && !bus_stop) |=> $stable(sda_pull_o));

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> (strap_done && $stable(own_addr)));

  a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state == ST_IDLE && !sda_pull_o));

  a_r3_start_receives: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state == ST_RX && !sda_pull_o));

  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 8'd1));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

endmodule

bind smb_strap_slave smb_strap_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_high(scl_high), .bus_start(bus_start),
  .bus_stop(bus_stop), .sda_pull_o(sda_pull_o), .own_addr(own_addr),
  .strap_done(strap_done), .wr_en(wr_en), .ptr(ptr), .state(state)
);

// File: tb/smb_strap_slave_test.sv
module smb_strap_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic s_lo = 1'b0;
  logic s_hi = 1'b1;
  logic sda_pull_o;
  wire  line = sda_m & ~sda_pull_o;

  int n_run = 0;
  int n_fail = 0;
  int r9_viol = 0;
  bit pull_seen = 0;
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;

  logic [7:0] mdl [8];
  logic [7:0] mptr;

  always #5 clk = ~clk;

  smb_strap_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .strap_sense_lo_i(s_lo), .strap_sense_hi_i(s_hi), .sda_pull_o(sda_pull_o)
  );

  // per-clock monitor: drive must not move while SCL stays high (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && prev_scl && (sda_pull_o != prev_pull)) r9_viol++;
      if (sda_pull_o) pull_seen = 1;
    end
    prev_scl  = scl;
    prev_pull = sda_pull_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lo, input logic hi);
    s_lo = lo; s_hi = hi; scl = 1; sda_m = 1; rst_n = 0;
    tick(5);
    rst_n = 1;
    tick(5);
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mptr = 8'h00;
  endtask

  task automatic bstart();
    sda_m = 1; tick(Q);
    scl = 1;   tick(Q);
    sda_m = 0; tick(Q);
    scl = 0;   tick(Q);
  endtask

  task automatic bstop();
    sda_m = 0; tick(Q);
    scl = 1;   tick(Q);
    sda_m = 1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1; tick(2*Q);
      scl = 0; tick(Q);
    end
    sda_m = 1; tick(Q);
    scl = 1; tick(Q);
    ack = line; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mnack);
    b = 8'h00;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1; tick(Q);
      b = {b[6:0], line}; tick(Q);
      scl = 0; tick(Q);
    end
    sda_m = mnack; tick(Q);
    scl = 1; tick(2*Q);
    scl = 0; tick(Q);
    sda_m = 1;
  endtask

  // write transfer to 0x2E: command then n data bytes, model updated
  task automatic wr_seq(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                        input string req);
    logic a;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    bstart();
    wbyte(8'h5C, a); chk(a == 1'b0, "R4 address ack", a, 0);
    wbyte(cmd, a);   chk(a == 1'b0, "R5 command ack", a, 0);
    mptr = cmd;
    for (int i = 0; i < n; i++) begin
      wbyte(d[i], a); chk(a == 1'b0, req, a, 0);
      mdl[mptr[2:0]] = d[i];
      mptr = mptr + 8'd1;
    end
    bstop();
  endtask

  // load pointer without STOP (repeated START follows)
  task automatic set_ptr(input logic [7:0] cmd);
    logic a;
    bstart();
    wbyte(8'h5C, a); chk(a == 1'b0, "R5 address ack", a, 0);
    wbyte(cmd, a);   chk(a == 1'b0, "R5 pointer ack", a, 0);
    mptr = cmd;
  endtask

  task automatic rd_seq(input int n, input string req);
    logic a;
    logic [7:0] b;
    bstart();
    wbyte(8'h5D, a); chk(a == 1'b0, "R7 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(b, (i == n-1));
      chk(b == mdl[mptr[2:0]], req, b, mdl[mptr[2:0]]);
      mptr = mptr + 8'd1;
    end
    bstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;

    // floating strap -> 0x2E
    do_reset(1'b0, 1'b1);
    chk(sda_pull_o == 1'b0, "R11 released after reset", sda_pull_o, 0);
    // strap moved to ground after reset: must not take effect (R2)
    s_lo = 0; s_hi = 0;
    tick(20);
    bstart();
    wbyte(8'h58, a); chk(a == 1'b1, "R2 late strap ignored (0x2C)", a, 1);
    bstop();

    // reset contents (R11)
    set_ptr(8'h00);
    rd_seq(1, "R11 register zero after reset");

    // write burst: pointer then data bytes (R5, R6)
    wr_seq(8'h03, 4, 8'hA5, 8'h3C, 8'h5A, 8'hC3, "R6 data ack");

    // read with master ack then nack (R7)
    set_ptr(8'h03);
    bstart();
    wbyte(8'h5D, a); chk(a == 1'b0, "R7 read address ack", a, 0);
    rbyte(b, 1'b0); chk(b == 8'hA5, "R7 first read byte", b, 8'hA5);
    rbyte(b, 1'b0); chk(b == 8'h3C, "R7 acked next byte", b, 8'h3C);
    rbyte(b, 1'b1); chk(b == 8'h5A, "R7 third byte", b, 8'h5A);
    mptr = 8'h06;
    // after nack: more clock pulses, slave stays off the bus (R8)
    pull_seen = 0;
    rbyte(b, 1'b1);
    chk(b == 8'hFF, "R8 line released after nack", b, 8'hFF);
    chk(pull_seen == 0, "R8 no drive after nack", pull_seen, 0);
    bstop();

    // read with no command continues at pointer 6 (R7)
    rd_seq(1, "R7 read continues from pointer");

    // foreign address: no ack, no store (R4)
    bstart();
    wbyte(8'h60, a); chk(a == 1'b1, "R4 foreign address nack", a, 1);
    wbyte(8'h03, a); chk(a == 1'b1, "R4 foreign byte nack", a, 1);
    wbyte(8'hEE, a); chk(a == 1'b1, "R4 foreign data nack", a, 1);
    bstop();
    set_ptr(8'h03);
    rd_seq(1, "R4 register untouched by foreign write");

    // pointer modulo and 8-bit wrap (R10)
    wr_seq(8'h09, 1, 8'h77, 8'h00, 8'h00, 8'h00, "R10 write at pointer 9");
    set_ptr(8'h01);
    rd_seq(1, "R10 pointer 9 reaches register 1");
    wr_seq(8'hFF, 2, 8'h11, 8'h22, 8'h00, 8'h00, "R10 write across 255");
    set_ptr(8'h07);
    rd_seq(2, "R10 wrap 7 to 0");

    // START in the middle of a byte (R3)
    bstart();
    wbyte(8'h5C, a); chk(a == 1'b0, "R3 address ack before abort", a, 0);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; tick(Q);
      scl = 1; tick(2*Q);
      scl = 0; tick(Q);
    end
    bstart();
    wbyte(8'h5C, a); chk(a == 1'b0, "R3 address ack after restart", a, 0);
    wbyte(8'h02, a); chk(a == 1'b0, "R3 command after restart", a, 0);
    wbyte(8'h99, a); chk(a == 1'b0, "R3 data after restart", a, 0);
    mdl[2] = 8'h99;
    bstop();
    chk(sda_pull_o == 1'b0, "R3 released after stop", sda_pull_o, 0);
    set_ptr(8'h02);
    rd_seq(1, "R3 store after restart");

    // strap decode table (R1)
    do_reset(1'b0, 1'b0);
    bstart(); wbyte(8'h58, a); chk(a == 1'b0, "R1 grounded -> 0x2C", a, 0); bstop();
    bstart(); wbyte(8'h5C, a); chk(a == 1'b1, "R1 grounded rejects 0x2E", a, 1); bstop();
    do_reset(1'b1, 1'b1);
    bstart(); wbyte(8'h5A, a); chk(a == 1'b0, "R1 high -> 0x2D", a, 0); bstop();
    bstart(); wbyte(8'h58, a); chk(a == 1'b1, "R1 high rejects 0x2C", a, 1); bstop();
    do_reset(1'b1, 1'b0);
    bstart(); wbyte(8'h5C, a); chk(a == 1'b0, "R1 inconsistent -> 0x2E", a, 0); bstop();
    set_ptr(8'h03);
    rd_seq(1, "R11 registers cleared by reset");

    chk(r9_viol == 0, "R9 drive steady while SCL high", r9_viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule